// File: doc/BRIEF.md
# Tree Dictionary Machine

This block is a small associative store built as a binary tree. Eight leaf slots each hold one key and its data word. Every command enters at the root. The command is registered once and presented to all leaves together. Each leaf produces a candidate record: a hit flag, its key, its data and its own slot number. Seven combining nodes, arranged in three registered levels, merge those candidates pairwise on the way back to the root. The merge rule depends on the operation. For a key lookup, a node passes on the OR of the two hit flags and the record of the child that hit. For a minimum or maximum query, it passes on the record with the smaller or larger key among the children that hold data.

Each combining node also keeps a count of the free slots below it. When an insert misses, the root walks these counts downward and lands on a free leaf. The leftmost subtree with room is preferred.

Reads move through the tree one per cycle, so lookups and extreme queries can be issued back to back. Insert and delete change the stored contents, so they hold off new commands until their update is complete. After a delete that removes a record, one extra cycle is spent raising the free counts along the freed leaf's path.

Top module: `dict_tree_machine`

## Requirements
- R1: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. Exactly one response follows. `resp_valid` is high for one cycle, and that cycle begins at the third rising edge after the accepting edge. Operation codes are: 1 lookup, 2 insert, 3 delete, 4 minimum, 5 maximum. Codes 0, 6 and 7 behave as a lookup.
- R2: A lookup returns `resp_found`=1 with the stored key and data when the key is present. It returns `resp_found`=0 when the key is absent.
- R3: Minimum and maximum return `resp_found`=1 with the smallest or largest stored key and that key's data. On an empty store they return `resp_found`=0.
- R4: An insert of a key that is not stored, while at least one slot is free, stores the record in a free slot and answers `resp_found`=0, `resp_full`=0. Eight distinct keys fill the store.
- R5: An insert of a key that is already stored replaces its data in the same slot, uses no extra slot, and answers `resp_found`=1 with the previous data. This also applies when the store is full.
- R6: A delete of a stored key answers `resp_found`=1 with the removed key and data, and frees its slot. A delete of an absent key answers `resp_found`=0 and changes nothing.
- R7: An insert of a new key while no slot is free answers `resp_full`=1, `resp_found`=0, and leaves the contents unchanged.
- R8: Lookups may be accepted on consecutive cycles. Their responses come back in order on consecutive cycles.
- R9: `cmd_ready` is low from the acceptance of an insert or delete until that command's update is done. After an insert, or a delete that misses, `cmd_ready` is high in the cycle after the response. After a delete that hits, `cmd_ready` is still low in that cycle, because the free counts are being raised.
- R10: After reset the store is empty, `cmd_ready` is 1 and `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_key | input | 8 | Key for lookup, insert or delete |
| cmd_data | input | 8 | Data word for insert |
| resp_valid | output | 1 | Response present this cycle |
| resp_found | output | 1 | Key matched, or an extreme exists |
| resp_full | output | 1 | Insert refused, no free slot |
| resp_key | output | 8 | Key of the returned record |
| resp_data | output | 8 | Data of the returned record (previous data on overwrite) |

## Verification
The bench targets four cases:
- Overwriting a key that is already present. A design that skipped the match check would spend a second slot. It would then report full too early, and a later minimum or delete would see a stale twin.
- A miss-delete followed by an insert into a full store. A design that decremented the free counts on overwrite, or raised them on a missing delete, would refuse a legal insert or accept one too many.
- Back-to-back lookups. These show whether the merge pipeline is truly one per cycle and keeps the data of the hitting child, rather than its sibling's.
- The ready level in the cycle after a delete's response. This exposes a design that lets a new command in before the free counts have caught up.

// File: rtl/dict_pkg.sv
package dict_pkg;
  parameter int unsigned KEY_W  = 8;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned LEAVES = 8;
  localparam int unsigned LVL   = $clog2(LEAVES);
  localparam int unsigned CNT_W = LVL + 1;

  typedef logic [KEY_W-1:0]  key_t;
  typedef logic [DATA_W-1:0] data_t;
  typedef logic [LVL-1:0]    idx_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SEARCH = 3'd1,
    OP_INSERT = 3'd2,
    OP_DELETE = 3'd3,
    OP_FMIN   = 3'd4,
    OP_FMAX   = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } op_e;

  typedef struct packed {
    logic  hit;
    idx_t  idx;
    key_t  key;
    data_t data;
  } rec_t;

  // depth of heap node n (root n=1 has depth 0)
  function automatic int flog2(int n);
    int r = 0;
    int v = n;
    while (v > 1) begin
      v = v >> 1;
      r++;
    end
    return r;
  endfunction

  // number of leaves below heap node n
  function automatic int sub_size(int n);
    return int'(LEAVES) >> flog2(n);
  endfunction

  // true when heap node n is an ancestor of leaf slot i
  function automatic logic on_path(int n, idx_t i);
    int h = int'(LEAVES) + int'(i);
    logic r = 1'b0;
    for (int s = 1; s <= int'(LVL); s++)
      if ((h >> s) == n) r = 1'b1;
    return r;
  endfunction

  // pairwise combine rule used by every internal node
  function automatic rec_t merge_rec(op_e op, rec_t a, rec_t b);
    case (op)
      OP_FMIN: begin
        if (a.hit && b.hit) return (a.key <= b.key) ? a : b;
        return a.hit ? a : b;
      end
      OP_FMAX: begin
        if (a.hit && b.hit) return (a.key >= b.key) ? a : b;
        return a.hit ? a : b;
      end
      default: return a.hit ? a : b;
    endcase
  endfunction
endpackage

// File: rtl/dict_leaf_bank.sv
module dict_leaf_bank
  import dict_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  op_e   op_i,
  input  key_t  key_i,
  input  logic  wr_en_i,
  input  idx_t  wr_idx_i,
  input  key_t  wr_key_i,
  input  data_t wr_data_i,
  input  logic  clr_en_i,
  input  idx_t  clr_idx_i,
  output rec_t  rec_o [LEAVES],
  output logic [LEAVES-1:0] free_o
);
  logic [LEAVES-1:0] vld_q;
  key_t  key_q [LEAVES];
  data_t dat_q [LEAVES];
  logic [LEAVES-1:0] hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < int'(LEAVES); i++) begin
        key_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < int'(LEAVES); i++) begin
        if (wr_en_i && wr_idx_i == idx_t'(i)) begin
          vld_q[i] <= 1'b1;
          key_q[i] <= wr_key_i;
          dat_q[i] <= wr_data_i;
        end else if (clr_en_i && clr_idx_i == idx_t'(i)) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < int'(LEAVES); i++) begin
      case (op_i)
        OP_FMIN, OP_FMAX: hit_vec[i] = vld_q[i];
        default:          hit_vec[i] = vld_q[i] && (key_q[i] == key_i);
      endcase
      rec_o[i].hit  = hit_vec[i];
      rec_o[i].idx  = idx_t'(i);
      rec_o[i].key  = key_q[i];
      rec_o[i].data = dat_q[i];
    end
  end

  assign free_o = ~vld_q;

  // stored keys stay unique: a key lookup never matches two slots
  assert_unique_keys_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != OP_FMIN && op_i != OP_FMAX) |-> $countones(hit_vec) <= 1);
  // a write never lands on a slot being cleared in the same cycle
  assert_no_write_clear_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && clr_en_i));
endmodule

// File: rtl/dict_merge_node.sv
module dict_merge_node
  import dict_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  op_i,
  input  rec_t a_i,
  input  rec_t b_i,
  output rec_t rec_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_o <= '0;
    else        rec_o <= merge_rec(op_i, a_i, b_i);
  end

  // a hit leaving this node came from a child that hit
  assert_hit_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_o.hit |-> $past(a_i.hit || b_i.hit));
  // minimum never passes a key above a live child key
  assert_min_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_o.hit && $past(op_i) == OP_FMIN && $past(a_i.hit)) |-> rec_o.key <= $past(a_i.key));
  assert_min_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_o.hit && $past(op_i) == OP_FMIN && $past(b_i.hit)) |-> rec_o.key <= $past(b_i.key));
  // maximum never passes a key below a live child key
  assert_max_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_o.hit && $past(op_i) == OP_FMAX && $past(a_i.hit)) |-> rec_o.key >= $past(a_i.key));
  assert_max_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_o.hit && $past(op_i) == OP_FMAX && $past(b_i.hit)) |-> rec_o.key >= $past(b_i.key));
endmodule

// File: rtl/dict_vacancy.sv
module dict_vacancy
  import dict_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic [LEAVES-1:0] leaf_free_i,
  input  logic take_i,
  input  idx_t take_idx_i,
  input  logic give_i,
  input  idx_t give_idx_i,
  input  logic pend_i,
  output cnt_t root_free_o,
  output idx_t pick_idx_o
);
  cnt_t cnt [LEAVES];   // heap-indexed, entry 0 unused

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < int'(LEAVES); n++) cnt[n] <= cnt_t'(sub_size(n));
    end else begin
      for (int n = 1; n < int'(LEAVES); n++) begin
        if (take_i && on_path(n, take_idx_i))      cnt[n] <= cnt[n] - 1'b1;
        else if (give_i && on_path(n, give_idx_i)) cnt[n] <= cnt[n] + 1'b1;
      end
    end
  end

  // walk down from the root, preferring the left child with room
  always_comb begin
    int h;
    h = 1;
    for (int lv = 0; lv < int'(LVL); lv++) begin
      int   l;
      logic room;
      l = 2 * h;
      if (l >= int'(LEAVES)) room = leaf_free_i[l - int'(LEAVES)];
      else                   room = (cnt[l] != '0);
      h = room ? l : l + 1;
    end
    pick_idx_o = idx_t'(h - int'(LEAVES));
  end

  assign root_free_o = cnt[1];

  // counters agree with the leaves except during a delete's raise pass
  assert_count_tracks_leaves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_i |-> root_free_o == cnt_t'($countones(leaf_free_i)));
  // the steered slot is really free whenever room exists
  assert_pick_is_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_i && root_free_o != '0) |-> leaf_free_i[pick_idx_o]);
  // never take a slot from a tree with no room
  assert_no_take_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> root_free_o != '0);
endmodule

// File: rtl/dict_tree_machine.sv
module dict_tree_machine
  import dict_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [KEY_W-1:0]  cmd_key,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              resp_valid,
  output logic              resp_found,
  output logic              resp_full,
  output logic [KEY_W-1:0]  resp_key,
  output logic [DATA_W-1:0] resp_data
);
  // stage 0 feeds the leaves, stage LVL sits beside the root register
  logic  s_vld [LVL+1];
  op_e   s_op  [LVL+1];
  key_t  s_key [LVL+1];
  data_t s_dat [LVL+1];

  logic busy_q, pend_q;
  idx_t pend_idx_q;
  logic accept;

  rec_t leaf_rec [LEAVES];
  rec_t node_rec [LEAVES];
  logic [LEAVES-1:0] leaf_free;

  cnt_t root_free;
  idx_t pick_idx;
  rec_t root;
  logic root_go, ins_go, del_go;
  logic wr_en, take, clr_en;
  idx_t wr_idx;

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s <= int'(LVL); s++) begin
        s_vld[s] <= 1'b0;
        s_op[s]  <= OP_NONE;
        s_key[s] <= '0;
        s_dat[s] <= '0;
      end
    end else begin
      s_vld[0] <= accept;
      s_op[0]  <= op_e'(cmd_op);
      s_key[0] <= cmd_key;
      s_dat[0] <= cmd_data;
      for (int s = 1; s <= int'(LVL); s++) begin
        s_vld[s] <= s_vld[s-1];
        s_op[s]  <= s_op[s-1];
        s_key[s] <= s_key[s-1];
        s_dat[s] <= s_dat[s-1];
      end
    end
  end

  dict_leaf_bank u_leaves (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (s_op[0]),
    .key_i     (s_key[0]),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_key_i  (s_key[LVL]),
    .wr_data_i (s_dat[LVL]),
    .clr_en_i  (clr_en),
    .clr_idx_i (root.idx),
    .rec_o     (leaf_rec),
    .free_o    (leaf_free)
  );

  assign node_rec[0] = '0;

  for (genvar n = 1; n < int'(LEAVES); n++) begin : g_node
    localparam int D = flog2(n);
    rec_t ca, cb;
    if (2 * n >= int'(LEAVES)) begin : g_leaf_kids
      assign ca = leaf_rec[2*n - int'(LEAVES)];
      assign cb = leaf_rec[2*n + 1 - int'(LEAVES)];
    end else begin : g_node_kids
      assign ca = node_rec[2*n];
      assign cb = node_rec[2*n + 1];
    end
    dict_merge_node u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .op_i  (s_op[int'(LVL) - 1 - D]),
      .a_i   (ca),
      .b_i   (cb),
      .rec_o (node_rec[n])
    );
  end

  dict_vacancy u_vac (
    .clk         (clk),
    .rst_n       (rst_n),
    .leaf_free_i (leaf_free),
    .take_i      (take),
    .take_idx_i  (pick_idx),
    .give_i      (pend_q),
    .give_idx_i  (pend_idx_q),
    .pend_i      (pend_q),
    .root_free_o (root_free),
    .pick_idx_o  (pick_idx)
  );

  // commit at the root
  assign root    = node_rec[1];
  assign root_go = s_vld[LVL];
  assign ins_go  = root_go && s_op[LVL] == OP_INSERT;
  assign del_go  = root_go && s_op[LVL] == OP_DELETE;
  assign take    = ins_go && !root.hit && root_free != '0;
  assign wr_en   = ins_go && (root.hit || root_free != '0);
  assign wr_idx  = root.hit ? root.idx : pick_idx;
  assign clr_en  = del_go && root.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      pend_q <= clr_en;
      if (clr_en) pend_idx_q <= root.idx;
      if (accept && (op_e'(cmd_op) == OP_INSERT || op_e'(cmd_op) == OP_DELETE))
        busy_q <= 1'b1;
      else if (ins_go || (del_go && !root.hit) || pend_q)
        busy_q <= 1'b0;
    end
  end

  assign resp_valid = root_go;
  assign resp_found = root_go && root.hit;
  assign resp_full  = ins_go && !root.hit && root_free == '0;
  assign resp_key   = root.key;
  assign resp_data  = root.data;

  // no command can slip in while the free counts are being raised
  assert_ready_low_in_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !cmd_ready);
  // a refused insert leaves every slot as it was
  assert_full_keeps_slots_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_full |=> $stable(leaf_free));
  // deleting an absent key leaves every slot as it was
  assert_miss_delete_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && s_op[LVL] == OP_DELETE && !resp_found) |=> $stable(leaf_free));
  // a response is never full and found together
  assert_full_excludes_found_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_full && resp_found));
endmodule

// File: tb/dict_tree_machine_test.sv
module dict_tree_machine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_key = 8'h00;
  logic [7:0] cmd_data = 8'h00;
  logic       resp_valid, resp_found, resp_full;
  logic [7:0] resp_key, resp_data;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic g_found, g_full;
  logic [7:0] g_key, g_data;

  always #2 clk = ~clk;

  dict_tree_machine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_data(cmd_data),
    .resp_valid(resp_valid), .resp_found(resp_found), .resp_full(resp_full),
    .resp_key(resp_key), .resp_data(resp_data)
  );

  localparam logic [2:0] SR = 3'd1, IN = 3'd2, DL = 3'd3, MN = 3'd4, MX = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] key;
    logic [7:0] dat;
    logic       ef;
    logic       eu;
    logic [7:0] ek;
    logic [7:0] ed;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VT [NV] = '{
    '{MN, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 4'd3},  // R3 empty min
    '{MX, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 4'd3},  // R3 empty max
    '{SR, 8'h10, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 4'd2},  // R2 absent
    '{IN, 8'h10, 8'hA1, 1'b0, 1'b0, 8'h00, 8'h00, 4'd4},  // R4
    '{IN, 8'h05, 8'hB2, 1'b0, 1'b0, 8'h00, 8'h00, 4'd4},
    '{IN, 8'h20, 8'hC3, 1'b0, 1'b0, 8'h00, 8'h00, 4'd4},
    '{SR, 8'h05, 8'h00, 1'b1, 1'b0, 8'h05, 8'hB2, 4'd2},  // R2 present
    '{IN, 8'h10, 8'hD4, 1'b1, 1'b0, 8'h10, 8'hA1, 4'd5},  // R5 overwrite
    '{SR, 8'h10, 8'h00, 1'b1, 1'b0, 8'h10, 8'hD4, 4'd5},
    '{MN, 8'h00, 8'h00, 1'b1, 1'b0, 8'h05, 8'hB2, 4'd3},  // R3
    '{MX, 8'h00, 8'h00, 1'b1, 1'b0, 8'h20, 8'hC3, 4'd3},
    '{DL, 8'h05, 8'h00, 1'b1, 1'b0, 8'h05, 8'hB2, 4'd6},  // R6 hit
    '{DL, 8'h05, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 4'd6},  // R6 miss
    '{MN, 8'h00, 8'h00, 1'b1, 1'b0, 8'h10, 8'hD4, 4'd6},
    '{IN, 8'h30, 8'h11, 1'b0, 1'b0, 8'h00, 8'h00, 4'd4},
    '{IN, 8'h40, 8'h12, 1'b0, 1'b0, 8'h00, 8'h00, 4'd4},
    '{IN, 8'h50, 8'h13, 1'b0, 1'b0, 8'h00, 8'h00, 4'd4},
    '{IN, 8'h60, 8'h14, 1'b0, 1'b0, 8'h00, 8'h00, 4'd4},
    '{IN, 8'h70, 8'h15, 1'b0, 1'b0, 8'h00, 8'h00, 4'd4},
    '{IN, 8'h80, 8'h16, 1'b0, 1'b0, 8'h00, 8'h00, 4'd4},  // R4 eighth key
    '{IN, 8'h90, 8'h17, 1'b0, 1'b1, 8'h00, 8'h00, 4'd7},  // R7 refused
    '{SR, 8'h90, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 4'd7},
    '{MX, 8'h00, 8'h00, 1'b1, 1'b0, 8'h80, 8'h16, 4'd7},
    '{IN, 8'h20, 8'hEE, 1'b1, 1'b0, 8'h20, 8'hC3, 4'd5},  // R5 overwrite while full
    '{SR, 8'h20, 8'h00, 1'b1, 1'b0, 8'h20, 8'hEE, 4'd5},
    '{DL, 8'h30, 8'h00, 1'b1, 1'b0, 8'h30, 8'h11, 4'd6},
    '{IN, 8'h90, 8'h17, 1'b0, 1'b0, 8'h00, 8'h00, 4'd4},  // R4 reuse freed slot
    '{MX, 8'h00, 8'h00, 1'b1, 1'b0, 8'h90, 8'h17, 4'd3},
    '{SR, 8'h40, 8'h00, 1'b1, 1'b0, 8'h40, 8'h12, 4'd2},
    '{MN, 8'h00, 8'h00, 1'b1, 1'b0, 8'h10, 8'hD4, 4'd3}
  };

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where the response is visible
  task automatic run_op(input logic [2:0] op, input logic [7:0] k, input logic [7:0] d);
    int w = 0;
    while (!cmd_ready && w < 100) begin @(negedge clk); w++; end
    cmd_valid = 1'b1; cmd_op = op; cmd_key = k; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    w = 0;
    while (!resp_valid && w < 100) begin @(negedge clk); w++; end
    g_found = resp_found; g_full = resp_full; g_key = resp_key; g_data = resp_data;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(10, "ready after reset", {31'd0, cmd_ready}, 32'd1);
    chk(10, "resp_valid after reset", {31'd0, resp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(10, "ready out of reset", {31'd0, cmd_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      run_op(VT[i].op, VT[i].key, VT[i].dat);
      chk(int'(VT[i].rq), $sformatf("vec %0d found", i), {31'd0, g_found}, {31'd0, VT[i].ef});
      chk(int'(VT[i].rq), $sformatf("vec %0d full", i), {31'd0, g_full}, {31'd0, VT[i].eu});
      if (VT[i].ef) begin
        chk(int'(VT[i].rq), $sformatf("vec %0d key", i), {24'd0, g_key}, {24'd0, VT[i].ek});
        chk(int'(VT[i].rq), $sformatf("vec %0d data", i), {24'd0, g_data}, {24'd0, VT[i].ed});
      end
      @(negedge clk);
    end

    // R8 back-to-back lookups; R1 timing of the first response
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = SR; cmd_key = 8'h40;
    @(negedge clk);
    cmd_key = 8'h90;
    @(negedge clk);
    cmd_key = 8'h33;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(1, "no response before third edge", {31'd0, resp_valid}, 32'd0);
    @(negedge clk);
    chk(8, "pipe 1 valid", {31'd0, resp_valid}, 32'd1);
    chk(8, "pipe 1 data", {31'd0, resp_found, resp_data}, {23'd0, 1'b1, 8'h12});
    @(negedge clk);
    chk(8, "pipe 2 valid", {31'd0, resp_valid}, 32'd1);
    chk(8, "pipe 2 data", {31'd0, resp_found, resp_data}, {23'd0, 1'b1, 8'h17});
    @(negedge clk);
    chk(8, "pipe 3 valid", {31'd0, resp_valid}, 32'd1);
    chk(8, "pipe 3 miss", {31'd0, resp_found}, 32'd0);
    @(negedge clk);
    chk(1, "single response per command", {31'd0, resp_valid}, 32'd0);

    // R1 reserved code acts as a lookup
    run_op(3'd6, 8'h70, 8'h00);
    chk(1, "code 6 lookup", {23'd0, g_found, g_data}, {23'd0, 1'b1, 8'h15});
    @(negedge clk);

    // R9 ready after a hitting delete stays low one more cycle
    run_op(DL, 8'h40, 8'h00);
    chk(6, "delete hit", {31'd0, g_found}, 32'd1);
    @(negedge clk);
    chk(9, "ready low during raise pass", {31'd0, cmd_ready}, 32'd0);
    @(negedge clk);
    chk(9, "ready back after raise pass", {31'd0, cmd_ready}, 32'd1);

    // R9 ready after insert is back immediately
    run_op(IN, 8'h33, 8'h44);
    chk(4, "insert into freed slot", {30'd0, g_found, g_full}, 32'd0);
    @(negedge clk);
    chk(9, "ready after insert", {31'd0, cmd_ready}, 32'd1);

    // R9 ready after a missing delete is back immediately
    run_op(DL, 8'hF0, 8'h00);
    chk(6, "delete miss", {31'd0, g_found}, 32'd0);
    @(negedge clk);
    chk(9, "ready after miss delete", {31'd0, cmd_ready}, 32'd1);

    // R7 store is full again: a new key is refused
    run_op(IN, 8'hF1, 8'h01);
    chk(7, "full after refill", {30'd0, g_found, g_full}, {30'd0, 1'b0, 1'b1});
    @(negedge clk);
    run_op(SR, 8'h33, 8'h00);
    chk(2, "lookup refilled key", {23'd0, g_found, g_data}, {23'd0, 1'b1, 8'h44});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule